// File: doc/BRIEF.md
# Branch-State Linear Diffusion Layer

This block applies the linear mixing stage of a branch-based permutation to a state of 4, 6 or 8 branches. Each branch is a pair of 32-bit words, x and y. The block XOR-folds the x words and the y words of the left half of the branches. It passes each fold through a 16-bit rotate-and-mix function. It then XORs the result into the right half, crossed so that the x fold lands in the y words and the y fold lands in the x words. Finally it rotates the branch order so that the two halves trade places.

The layer is registered. The caller presents the whole state on a flat bus and pulses `start_i`. One cycle later the new state appears on `state_o` and `done_o` pulses for one cycle. The result stays on `state_o` until the next start. A two-bit select chooses the branch count. Words above the selected branch count are passed through untouched. The fourth select code copies the whole state through unchanged.

Top module: `lin_layer`

## Requirements
- R1: While `rst_ni` is low, `state_o` is all zero and `done_o` is low.
- R2: A start in cycle n gives `done_o` high in cycle n+1 only, with the new state on `state_o` in that cycle. Without a start, `state_o` holds its value.
- R3: Word packing and the mixing function. Branch i has x[i] at bits [64i+31:64i] and y[i] at bits [64i+63:64i+32]. With hb = nb/2, fx is the XOR of x[0..hb-1] and fy is the XOR of y[0..hb-1]. mix(w) = {w[15:0], w[31:16] ^ w[15:0]}. For 0 ≤ j < hb-1, the new x[j] is x[j+1+hb] ^ x[j+1] ^ mix(fy).
- R4: The wrap-around term: the new x[hb-1] is x[hb] ^ x[0] ^ mix(fy), and the new y[hb-1] is y[hb] ^ y[0] ^ mix(fx).
- R5: For 0 ≤ j < hb, the new branch j+hb equals the old branch j, both x and y.
- R6: The crossed term: for 0 ≤ j < hb-1, the new y[j] is y[j+1+hb] ^ y[j+1] ^ mix(fx).
- R7: Select encoding on `nb_sel_i`: 0 selects 4 branches, 1 selects 6 branches, 2 selects 8 branches.
- R8: When fewer than 8 branches are selected, the words of branches nb..7 pass through to `state_o` unchanged.
- R9: Select code 3 copies `state_i` to `state_o` unchanged.
- R10: An all-zero input state yields an all-zero output state for every select code.
- R11: The layer is linear: out(a ^ b) = out(a) ^ out(b) for the same select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture and transform `state_i` this cycle |
| nb_sel_i | input | 2 | Branch-count select (R7, R9) |
| state_i | input | 512 | Input state, packed as in R3 |
| state_o | output | 512 | Registered output state |
| done_o | output | 1 | One-cycle pulse when `state_o` is updated |

## Verification
The embedded assertions check the following on every cycle:
- the handshake timing and the hold of `state_o` between starts;
- the zero-maps-to-zero property;
- the pass-through of the upper words in the 4-branch mode;
- the full copy under the bypass code.

The word-level algebra needs concrete stimulus, and only the bench scenarios can show it: the crossed fold terms, the wrap-around index, the half swap, the 6-branch boundary and linearity. The bench compares each of these against expectations it computes word by word.

// File: rtl/lin_pkg.sv
package lin_pkg;
  typedef enum logic [1:0] {
    NB_SEL_4   = 2'd0,
    NB_SEL_6   = 2'd1,
    NB_SEL_8   = 2'd2,
    NB_SEL_BYP = 2'd3
  } nb_sel_e;

  localparam int unsigned NUM_VARIANTS = 3;
  localparam int unsigned MIN_BRANCHES = 4;
endpackage

// File: rtl/half_fold.sv
module half_fold #(
  parameter int unsigned HB = 2,
  parameter int unsigned W  = 32
) (
  input  logic [HB*W-1:0] words_i,
  output logic [W-1:0]    fold_o
);
  always_comb begin
    fold_o = '0;
    for (int k = 0; k < int'(HB); k++) fold_o ^= words_i[k*W +: W];
  end
endmodule

// File: rtl/ell_mix.sv
module ell_mix #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] w_i,
  output logic [W-1:0] w_o
);
  localparam int unsigned H = W / 2;
  // swap halves, then fold new upper into new lower
  assign w_o = {w_i[H-1:0], w_i[W-1:H] ^ w_i[H-1:0]};
endmodule

// File: rtl/lin_variant.sv
module lin_variant #(
  parameter int unsigned NB   = 4,
  parameter int unsigned MAXB = 8,
  parameter int unsigned W    = 32
) (
  input  logic [2*MAXB*W-1:0] state_i,
  output logic [2*MAXB*W-1:0] state_o
);
  localparam int unsigned HB = NB / 2;
  localparam int unsigned SW = 2 * MAXB * W;

  logic [HB*W-1:0] xs, ys;
  logic [W-1:0]    fx, fy, ex, ey;

  for (genvar j = 0; j < int'(HB); j++) begin : g_gather
    assign xs[j*W +: W] = state_i[(2*j)*W +: W];
    assign ys[j*W +: W] = state_i[(2*j+1)*W +: W];
  end

  half_fold #(.HB(HB), .W(W)) u_fold_x (.words_i(xs), .fold_o(fx));
  half_fold #(.HB(HB), .W(W)) u_fold_y (.words_i(ys), .fold_o(fy));
  ell_mix   #(.W(W))          u_mix_x  (.w_i(fx), .w_o(ex));
  ell_mix   #(.W(W))          u_mix_y  (.w_i(fy), .w_o(ey));

  for (genvar j = 0; j < int'(HB); j++) begin : g_mix
    localparam int unsigned L = (j + 1) % HB;  // wraps to 0 on last branch
    localparam int unsigned R = HB + L;
    // crossed: y fold into x words, x fold into y words
    assign state_o[(2*j)*W +: W]   = state_i[(2*R)*W +: W]   ^ state_i[(2*L)*W +: W]   ^ ey;
    assign state_o[(2*j+1)*W +: W] = state_i[(2*R+1)*W +: W] ^ state_i[(2*L+1)*W +: W] ^ ex;
    assign state_o[(2*(j+HB))*W +: 2*W] = state_i[(2*j)*W +: 2*W];
  end

  if (NB < MAXB) begin : g_upper
    assign state_o[SW-1:2*NB*W] = state_i[SW-1:2*NB*W];
  end
endmodule

// File: rtl/lin_layer.sv
module lin_layer #(
  parameter int unsigned MAX_BRANCHES = 8,
  parameter int unsigned WORD_W       = 32
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                start_i,
  input  logic [1:0]                          nb_sel_i,
  input  logic [2*MAX_BRANCHES*WORD_W-1:0]    state_i,
  output logic [2*MAX_BRANCHES*WORD_W-1:0]    state_o,
  output logic                                done_o
);
  import lin_pkg::*;

  localparam int unsigned SW  = 2 * MAX_BRANCHES * WORD_W;
  localparam int unsigned LO4 = 2 * MIN_BRANCHES * WORD_W;

  logic [SW-1:0] var_res [NUM_VARIANTS];
  logic [SW-1:0] nxt;
  logic [SW-1:0] state_q;
  logic          done_q;

  for (genvar g = 0; g < int'(NUM_VARIANTS); g++) begin : g_var
    lin_variant #(
      .NB  (MIN_BRANCHES + 2*g),
      .MAXB(MAX_BRANCHES),
      .W   (WORD_W)
    ) u_var (
      .state_i(state_i),
      .state_o(var_res[g])
    );
  end

  always_comb begin
    unique case (nb_sel_i)
      NB_SEL_4: nxt = var_res[0];
      NB_SEL_6: nxt = var_res[1];
      NB_SEL_8: nxt = var_res[2];
      default:  nxt = state_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= start_i;
      if (start_i) state_q <= nxt;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;

  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(state_o)); // R2
  AST_ZERO_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_i == '0) |=> state_o == '0); // R10
  AST_UPPER_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && nb_sel_i == NB_SEL_4) |=> state_o[SW-1:LO4] == $past(state_i[SW-1:LO4])); // R8
  AST_BYPASS_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && nb_sel_i == NB_SEL_BYP) |=> state_o == $past(state_i)); // R9
endmodule

// File: tb/tb_lin_layer.sv
module tb_lin_layer;
  localparam int SW = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    sel = 2'd0;
  logic [SW-1:0] sin = '0;
  logic [SW-1:0] sout;
  logic          done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lin_layer dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .nb_sel_i(sel),
    .state_i(sin), .state_o(sout), .done_o(done)
  );

  function automatic logic [31:0] mixf(input logic [31:0] w);
    logic [31:0] t;
    t = w ^ (w << 16);
    return {t[15:0], t[31:16]};
  endfunction

  function automatic logic [31:0] wd(input logic [SW-1:0] s, input int k);
    return s[k*32 +: 32];
  endfunction

  function automatic logic [SW-1:0] ref_layer(input logic [SW-1:0] s, input logic [1:0] c);
    logic [31:0] x [8];
    logic [31:0] y [8];
    logic [31:0] tx, ty;
    logic [SW-1:0] r;
    int nb, hb;
    if (c == 2'd3) return s;
    nb = 4 + 2 * int'(c);
    hb = nb / 2;
    for (int i = 0; i < 8; i++) begin
      x[i] = wd(s, 2*i);
      y[i] = wd(s, 2*i+1);
    end
    tx = 0; ty = 0;
    for (int i = 0; i < hb; i++) begin
      tx ^= x[i];
      ty ^= y[i];
    end
    r = s;
    for (int i = 0; i < hb; i++) begin
      int src;
      src = (i == hb - 1) ? 0 : i + 1;
      r[(2*i)*32 +: 32]        = x[src + hb] ^ x[src] ^ mixf(ty);
      r[(2*i+1)*32 +: 32]      = y[src + hb] ^ y[src] ^ mixf(tx);
      r[(2*(i+hb))*32 +: 32]   = x[i];
      r[(2*(i+hb)+1)*32 +: 32] = y[i];
    end
    return r;
  endfunction

  function automatic logic [SW-1:0] pattern(input int seed);
    logic [SW-1:0] p;
    for (int k = 0; k < 16; k++)
      p[k*32 +: 32] = (32'h9E3779B9 * (k + 1 + seed * 17)) ^ (32'h0F0F1234 << (k % 8)) ^ seed;
    return p;
  endfunction

  // cycle model
  logic [SW-1:0] exp_state;
  logic          exp_done;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_state <= '0;
      exp_done  <= 1'b0;
    end else begin
      exp_done <= start;
      if (start) exp_state <= ref_layer(sin, sel);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (done !== exp_done) begin
        errors++;
        $display("FAIL R2 done act=%0b exp=%0b", done, exp_done);
      end
      checks++;
      if (sout !== exp_state) begin
        errors++;
        $display("FAIL R3 state act=%h exp=%h", sout, exp_state);
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [SW-1:0] a, input logic [SW-1:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, a, e);
    end
  endtask

  task automatic run(input logic [SW-1:0] s, input logic [1:0] c, output logic [SW-1:0] res);
    @(negedge clk);
    sin = s; sel = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    res = sout;
  endtask

  task automatic word_checks(input logic [SW-1:0] s, input logic [1:0] c, input logic [SW-1:0] o);
    int hb;
    logic [31:0] tx, ty, e;
    hb = (4 + 2 * int'(c)) / 2;
    tx = 0; ty = 0;
    for (int i = 0; i < hb; i++) begin
      tx ^= wd(s, 2*i);
      ty ^= wd(s, 2*i+1);
    end
    for (int j = 0; j < hb - 1; j++) begin
      e = wd(s, 2*(j+1+hb)) ^ wd(s, 2*(j+1)) ^ mixf(ty);
      chk(wd(o, 2*j) == e, "R3 x fold", SW'(wd(o, 2*j)), SW'(e));
      e = wd(s, 2*(j+1+hb)+1) ^ wd(s, 2*(j+1)+1) ^ mixf(tx);
      chk(wd(o, 2*j+1) == e, "R6 y crossed", SW'(wd(o, 2*j+1)), SW'(e));
    end
    e = wd(s, 2*hb) ^ wd(s, 0) ^ mixf(ty);
    chk(wd(o, 2*(hb-1)) == e, "R4 x wrap", SW'(wd(o, 2*(hb-1))), SW'(e));
    e = wd(s, 2*hb+1) ^ wd(s, 1) ^ mixf(tx);
    chk(wd(o, 2*(hb-1)+1) == e, "R4 y wrap", SW'(wd(o, 2*(hb-1)+1)), SW'(e));
    for (int j = 0; j < hb; j++)
      chk(o[(2*(j+hb))*32 +: 64] == s[(2*j)*32 +: 64], "R5 half swap",
          SW'(o[(2*(j+hb))*32 +: 64]), SW'(s[(2*j)*32 +: 64]));
    for (int k = 4*hb; k < 16; k++)
      chk(wd(o, k) == wd(s, k), "R8 upper pass", SW'(wd(o, k)), SW'(wd(s, k)));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [SW-1:0] o, oa, ob, oab, a, b;
    repeat (2) @(negedge clk);
    chk(sout == '0, "R1 reset state", sout, '0);
    chk(done == 1'b0, "R1 reset done", SW'(done), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7: each select code, several patterns
    for (int c = 0; c < 3; c++) begin
      for (int p = 0; p < 3; p++) begin
        a = pattern(p + 4*c);
        run(a, 2'(c), o);
        chk(done == 1'b1, "R2 done pulse", SW'(done), SW'(1));
        chk(o == ref_layer(a, 2'(c)), "R7 select", o, ref_layer(a, 2'(c)));
        word_checks(a, 2'(c), o);
        @(negedge clk);
        chk(done == 1'b0 && sout == o, "R2 hold after done", sout, o);
      end
    end

    // single-bit inputs probe the mixing function
    for (int bit_i = 0; bit_i < 32; bit_i += 15) begin
      a = '0;
      a[bit_i] = 1'b1;
      a[32 + 31 - bit_i] = 1'b1;
      run(a, 2'd2, o);
      word_checks(a, 2'd2, o);
    end

    // R9 bypass
    a = pattern(99);
    run(a, 2'd3, o);
    chk(o == a, "R9 bypass", o, a);

    // R10 zero maps to zero
    for (int c = 0; c < 4; c++) begin
      run('0, 2'(c), o);
      chk(o == '0, "R10 zero map", o, '0);
    end

    // R11 linearity
    for (int c = 0; c < 3; c++) begin
      a = pattern(40 + c);
      b = pattern(60 + c);
      run(a, 2'(c), oa);
      run(b, 2'(c), ob);
      run(a ^ b, 2'(c), oab);
      chk(oab == (oa ^ ob), "R11 linearity", oab, oa ^ ob);
    end

    // back-to-back starts
    @(negedge clk);
    sin = pattern(7); sel = 2'd1; start = 1'b1;
    @(negedge clk);
    chk(sout == ref_layer(pattern(7), 2'd1), "R2 back to back first", sout, ref_layer(pattern(7), 2'd1));
    sin = pattern(8);
    @(negedge clk);
    start = 1'b0;
    chk(sout == ref_layer(pattern(8), 2'd1), "R2 back to back second", sout, ref_layer(pattern(8), 2'd1));
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule